// File: doc/BRIEF.md
# Byte-Packing Data Buffer

This block sits between a 16-bit CPU data port and a byte-wide serial shift engine. It keeps two small byte stores, one for each direction, each up to four bytes deep. On the transmit side the CPU writes 16-bit words, or one final 8-bit value for a transfer of odd length. The engine then takes bytes out one at a time, oldest first. On the receive side the engine deposits bytes one at a time, and the CPU collects them two at a time as a 16-bit word.

A single order-select input sets how the two bytes of a 16-bit word map onto the serial byte stream, in both directions. The block reports a fill level for each direction. It also raises underflow, overrun, ready and short-read indications toward a separate status unit, which owns masking and software clearing. Register decoding and bus timing are done elsewhere. All state is held in registers, and the two data outputs are combinational views of that state.

Top module: `byte_pack_buffer`

## Requirements
- R1: While `rst_n` is low at a clock edge, both levels, every flag and both stored byte sets return to zero.
- R2: A word write (`cpu_wr_word`) is accepted when `tx_level` is at most DEPTH-2, and it raises `tx_level` by two. With `order_swap`=0 the engine receives `cpu_wdata[7:0]` before `cpu_wdata[15:8]`. With `order_swap`=1 it receives `cpu_wdata[15:8]` first.
- R3: A byte write (`cpu_wr_byte` without `cpu_wr_word`) is accepted when `tx_level` is at most DEPTH-1. It raises `tx_level` by one and queues `cpu_wdata[7:0]` behind every earlier byte.
- R4: A write that does not fit is ignored. The level and the queued bytes stay unchanged.
- R5: Any write, whether accepted or not, clears `tx_underflow` and `tx_ready` on the next edge, unless an empty pop happens in the same cycle.
- R6: `eng_tx_byte` always shows the oldest queued byte, or zero when the store is empty. A pop on a non-empty store removes that byte and lowers `tx_level` by one.
- R7: A pop on an empty store sets `tx_underflow` and `tx_ready`, and `tx_level` stays at zero.
- R8: A push that fits stores `eng_rx_byte` behind the bytes already held, raises `rx_level` by one and sets `rx_ready`.
- R9: A push into a full store (full after any same-cycle read) sets `rx_overrun` and `rx_ready`, and the stored bytes do not change.
- R10: With `order_swap`=0, `cpu_rdata[7:0]` is the oldest received byte and `cpu_rdata[15:8]` the next one. With `order_swap`=1 the halves are exchanged. Any position that holds no valid byte reads as zero.
- R11: A word read (`cpu_rd_word`) with two or more bytes held removes two bytes and lowers `rx_level` by two. Every read clears `rx_ready` and `rx_overrun`, unless a push in the same cycle sets them again.
- R12: A read with exactly one byte held empties the store and pulses `rx_short_read` high for one cycle. A read with nothing held leaves the store alone and gives no pulse.
- R13: When a read and a push happen in the same cycle, the read is applied first, and the pushed byte lands behind whatever bytes remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| order_swap | input | 1 | Byte order select inside a 16-bit word |
| cpu_wr_word | input | 1 | CPU 16-bit write strobe |
| cpu_wr_byte | input | 1 | CPU 8-bit write strobe (last write of a transfer) |
| cpu_wdata | input | 16 | CPU write data |
| cpu_rd_word | input | 1 | CPU 16-bit read strobe |
| cpu_rdata | output | 16 | Oldest two received bytes, ordered by `order_swap` |
| eng_tx_pop | input | 1 | Engine takes one transmit byte |
| eng_tx_byte | output | 8 | Oldest transmit byte |
| eng_rx_push | input | 1 | Engine delivers one received byte |
| eng_rx_byte | input | 8 | Received byte |
| tx_level | output | 3 | Transmit bytes held |
| rx_level | output | 3 | Receive bytes held |
| tx_underflow | output | 1 | Pop seen on an empty transmit store |
| tx_ready | output | 1 | Transmit side wants data |
| rx_overrun | output | 1 | Push lost because the receive store was full |
| rx_ready | output | 1 | Received data available |
| rx_short_read | output | 1 | One-cycle pulse: a read found only one valid byte |

## Verification
Levels and flags are registered, so the effect of a strobe seen at one rising edge appears exactly one edge later. `eng_tx_byte` and `cpu_rdata` are combinational views of the held bytes, so they reflect the state left by the previous edge and `order_swap` as currently driven. The bench drives strobes at the falling edge. At the next falling edge it compares the registered outputs with a queue-based model that has absorbed the previous strobes. It compares the two data outputs one nanosecond after driving, before the model takes in the new strobes. Directed sequences cover both byte orders, full and empty boundaries, and same-cycle read/push and pop/write cases, and a long random run follows.

// File: rtl/bpk_pkg.sv
// Shared definitions for the byte-packing buffer.
// Assumes bytes are 8 bits and a CPU word is two bytes.
package bpk_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/bpk_tx_stack.sv
// Transmit byte store. CPU writes shift new bytes into the low end and the
// engine takes the oldest byte from position level-1.
// Assumes word and byte write strobes are not raised together (word wins).
module bpk_tx_stack
    import bpk_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          swap,
    input  logic                          wr_word,
    input  logic                          wr_byte,
    input  logic [WORD_W-1:0]             wdata,
    input  logic                          pop,
    output byte_t                         pop_byte,
    output logic [$clog2(DEPTH+1)-1:0]    level,
    output logic                          underflow,
    output logic                          ready
);
    localparam int CW = $clog2(DEPTH+1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0][BYTE_W-1:0] mem, nxt;
    logic [CW-1:0] level_q, top_idx;
    logic          take, empty_pop, acc_word, acc_byte, any_wr;
    byte_t         first_b, second_b;

    // Acceptance decisions, byte ordering and the oldest-byte view.
    always_comb begin
        take      = pop && (level_q != '0);
        empty_pop = pop && (level_q == '0);
        acc_word  = wr_word && (level_q <= CW'(DEPTH-2));
        acc_byte  = !wr_word && wr_byte && (level_q <= CW'(DEPTH-1));
        any_wr    = wr_word || wr_byte;
        first_b   = swap ? wdata[WORD_W-1:BYTE_W] : wdata[BYTE_W-1:0];
        second_b  = swap ? wdata[BYTE_W-1:0] : wdata[WORD_W-1:BYTE_W];
        top_idx   = level_q - CW'(1);
        pop_byte  = (level_q == '0) ? '0 : mem[top_idx[IW-1:0]];
    end

    // Per-lane next value: shift by two for a word, by one for a byte.
    for (genvar i = 0; i < DEPTH; i++) begin : g_lane
        byte_t word_in, byte_in;
        if (i >= 2) begin : g_wshift
            assign word_in = mem[i-2];
        end else if (i == 1) begin : g_wfirst
            assign word_in = first_b;
        end else begin : g_wsecond
            assign word_in = second_b;
        end
        if (i >= 1) begin : g_bshift
            assign byte_in = mem[i-1];
        end else begin : g_bnew
            assign byte_in = wdata[BYTE_W-1:0];
        end
        assign nxt[i] = acc_word ? word_in : (acc_byte ? byte_in : mem[i]);
    end

    // Store, level and flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem       <= '0;
            level_q   <= '0;
            underflow <= 1'b0;
            ready     <= 1'b0;
        end else begin
            mem     <= nxt;
            level_q <= level_q + (acc_word ? CW'(2) : (acc_byte ? CW'(1) : CW'(0)))
                               - (take ? CW'(1) : CW'(0));
            if (empty_pop) begin
                underflow <= 1'b1;
                ready     <= 1'b1;
            end else if (any_wr) begin
                underflow <= 1'b0;
                ready     <= 1'b0;
            end
        end
    end

    assign level = level_q;

    a_r2_word_adds_two: assert property (@(posedge clk) disable iff (!rst_n)
        wr_word && !pop && (level_q <= CW'(DEPTH-2)) |=> level_q == CW'($past(level_q) + CW'(2)));
    a_r4_no_room_hold: assert property (@(posedge clk) disable iff (!rst_n)
        wr_word && !pop && (level_q > CW'(DEPTH-2)) |=> level_q == $past(level_q));
    a_r5_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        any_wr && !(pop && level_q == '0) |=> !underflow && !ready);
    a_r7_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        pop && !wr_word && !wr_byte && (level_q == '0) |=> underflow && ready && level_q == '0);
    a_r6_pop_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        pop && !wr_word && !wr_byte && (level_q != '0) |=> level_q == CW'($past(level_q) - CW'(1)));
endmodule

// File: rtl/bpk_rx_stack.sv
// Receive byte store. The engine writes each byte at position level, and a
// CPU read takes positions 0 and 1 and shifts the rest down by two.
// Assumes positions at or above level always hold zero.
module bpk_rx_stack
    import bpk_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          swap,
    input  logic                          rd_word,
    output logic [WORD_W-1:0]             rdata,
    input  logic                          push,
    input  byte_t                         push_byte,
    output logic [$clog2(DEPTH+1)-1:0]    level,
    output logic                          overrun,
    output logic                          ready,
    output logic                          short_read
);
    localparam int CW = $clog2(DEPTH+1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0][BYTE_W-1:0] mem, shifted, nxt;
    logic [CW-1:0] level_q, consume, base;
    logic          rd_any, fits, store;

    // Read-first consumption, then placement of a pushed byte.
    always_comb begin
        rd_any  = rd_word && (level_q != '0);
        consume = rd_any ? ((level_q >= CW'(2)) ? CW'(2) : CW'(1)) : '0;
        base    = level_q - consume;
        fits    = base < CW'(DEPTH);
        store   = push && fits;
        shifted = rd_any ? (mem >> WORD_W) : mem;
        nxt     = shifted;
        if (store) nxt[base[IW-1:0]] = push_byte;
        rdata   = swap ? {mem[0], mem[1]} : {mem[1], mem[0]};
    end

    // Store, level and flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem        <= '0;
            level_q    <= '0;
            overrun    <= 1'b0;
            ready      <= 1'b0;
            short_read <= 1'b0;
        end else begin
            mem        <= nxt;
            level_q    <= base + (store ? CW'(1) : CW'(0));
            short_read <= rd_word && (level_q == CW'(1));
            if (push && !fits) overrun <= 1'b1;
            else if (rd_word)  overrun <= 1'b0;
            if (push)          ready <= 1'b1;
            else if (rd_word)  ready <= 1'b0;
        end
    end

    assign level = level_q;

    a_r8_push_adds: assert property (@(posedge clk) disable iff (!rst_n)
        push && !rd_word && (level_q < CW'(DEPTH)) |=> ready && level_q == CW'($past(level_q) + CW'(1)));
    a_r9_overflow_holds: assert property (@(posedge clk) disable iff (!rst_n)
        push && !rd_word && (level_q == CW'(DEPTH)) |=> overrun && ready && level_q == CW'(DEPTH));
    a_r11_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rd_word && !push |=> !ready && !overrun);
    a_r12_short_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_word && !push && (level_q == CW'(1)) |=> short_read && level_q == '0);
    a_r12_no_pulse_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_word |=> !short_read);
endmodule

// File: rtl/byte_pack_buffer.sv
// Top of the byte-packing buffer: one transmit store and one receive store
// sharing the byte-order select. Holds no logic of its own.
module byte_pack_buffer
    import bpk_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH+1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              order_swap,
    input  logic              cpu_wr_word,
    input  logic              cpu_wr_byte,
    input  logic [WORD_W-1:0] cpu_wdata,
    input  logic              cpu_rd_word,
    output logic [WORD_W-1:0] cpu_rdata,
    input  logic              eng_tx_pop,
    output logic [BYTE_W-1:0] eng_tx_byte,
    input  logic              eng_rx_push,
    input  logic [BYTE_W-1:0] eng_rx_byte,
    output logic [CW-1:0]     tx_level,
    output logic [CW-1:0]     rx_level,
    output logic              tx_underflow,
    output logic              tx_ready,
    output logic              rx_overrun,
    output logic              rx_ready,
    output logic              rx_short_read
);
    bpk_tx_stack #(.DEPTH(DEPTH)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .swap      (order_swap),
        .wr_word   (cpu_wr_word),
        .wr_byte   (cpu_wr_byte),
        .wdata     (cpu_wdata),
        .pop       (eng_tx_pop),
        .pop_byte  (eng_tx_byte),
        .level     (tx_level),
        .underflow (tx_underflow),
        .ready     (tx_ready)
    );

    bpk_rx_stack #(.DEPTH(DEPTH)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .swap       (order_swap),
        .rd_word    (cpu_rd_word),
        .rdata      (cpu_rdata),
        .push       (eng_rx_push),
        .push_byte  (eng_rx_byte),
        .level      (rx_level),
        .overrun    (rx_overrun),
        .ready      (rx_ready),
        .short_read (rx_short_read)
    );
endmodule

// File: tb/tb_byte_pack_buffer.sv
`timescale 1ns/1ps
module tb_byte_pack_buffer;
    localparam real HALF = 2.5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        order_swap = 1'b0;
    logic        cpu_wr_word = 1'b0, cpu_wr_byte = 1'b0, cpu_rd_word = 1'b0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        eng_tx_pop = 1'b0, eng_rx_push = 1'b0;
    logic [7:0]  eng_tx_byte, eng_rx_byte = '0;
    logic [2:0]  tx_level, rx_level;
    logic        tx_underflow, tx_ready, rx_overrun, rx_ready, rx_short_read;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    // Reference model state
    logic [7:0] txq[$];
    logic [7:0] rxq[$];
    bit m_xu = 0, m_xr = 0, m_ov = 0, m_rr = 0, m_sb = 0;

    always #(HALF) clk = ~clk;

    byte_pack_buffer dut (
        .clk(clk), .rst_n(rst_n), .order_swap(order_swap),
        .cpu_wr_word(cpu_wr_word), .cpu_wr_byte(cpu_wr_byte), .cpu_wdata(cpu_wdata),
        .cpu_rd_word(cpu_rd_word), .cpu_rdata(cpu_rdata),
        .eng_tx_pop(eng_tx_pop), .eng_tx_byte(eng_tx_byte),
        .eng_rx_push(eng_rx_push), .eng_rx_byte(eng_rx_byte),
        .tx_level(tx_level), .rx_level(rx_level),
        .tx_underflow(tx_underflow), .tx_ready(tx_ready),
        .rx_overrun(rx_overrun), .rx_ready(rx_ready), .rx_short_read(rx_short_read)
    );

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_regs();
        chk("R2 R3 R4 R6 tx_level", int'(tx_level), txq.size());
        chk("R8 R11 R12 R13 rx_level", int'(rx_level), rxq.size());
        chk("R5 R7 tx_underflow", int'(tx_underflow), int'(m_xu));
        chk("R5 R7 tx_ready", int'(tx_ready), int'(m_xr));
        chk("R9 R11 rx_overrun", int'(rx_overrun), int'(m_ov));
        chk("R8 R9 R11 rx_ready", int'(rx_ready), int'(m_rr));
        chk("R12 rx_short_read", int'(rx_short_read), int'(m_sb));
    endtask

    // One clock: check registered state, drive, check views, advance model.
    task automatic cycle(input bit w16, input bit w8, input logic [15:0] wd,
                         input bit rd, input bit pop, input bit push,
                         input logic [7:0] pb, input bit sw);
        logic [7:0] b0, b1;
        int n, m;
        bit ov_evt;
        @(negedge clk);
        chk_regs();
        cpu_wr_word = w16; cpu_wr_byte = w8; cpu_wdata = wd; cpu_rd_word = rd;
        eng_tx_pop = pop; eng_rx_push = push; eng_rx_byte = pb; order_swap = sw;
        #1;
        chk("R2 R3 R6 eng_tx_byte", int'(eng_tx_byte), (txq.size() > 0) ? int'(txq[0]) : 0);
        b0 = (rxq.size() > 0) ? rxq[0] : 8'h00;
        b1 = (rxq.size() > 1) ? rxq[1] : 8'h00;
        chk("R10 R13 cpu_rdata", int'(cpu_rdata), sw ? int'({b0, b1}) : int'({b1, b0}));
        // transmit side
        n = txq.size();
        if (pop && n > 0) void'(txq.pop_front());
        if (w16 && n <= 2) begin
            if (sw) begin txq.push_back(wd[15:8]); txq.push_back(wd[7:0]); end
            else    begin txq.push_back(wd[7:0]);  txq.push_back(wd[15:8]); end
        end else if (!w16 && w8 && n <= 3) begin
            txq.push_back(wd[7:0]);
        end
        if (pop && n == 0) begin m_xu = 1; m_xr = 1; end
        else if (w16 || w8) begin m_xu = 0; m_xr = 0; end
        // receive side: read applies before push
        m = rxq.size();
        m_sb = rd && (m == 1);
        if (rd) begin
            if (m >= 1) void'(rxq.pop_front());
            if (m >= 2) void'(rxq.pop_front());
        end
        ov_evt = 0;
        if (push) begin
            if (rxq.size() < 4) rxq.push_back(pb);
            else ov_evt = 1;
        end
        if (ov_evt)  m_ov = 1; else if (rd) m_ov = 0;
        if (push)    m_rr = 1; else if (rd) m_rr = 0;
    endtask

    task automatic idle(input bit sw);
        cycle(0, 0, 16'h0, 0, 0, 0, 8'h0, sw);
    endtask

    // Watchdog
    initial begin
        #(2.0 * HALF * 200000);
        if (!done) begin
            misses++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 tx_level", int'(tx_level), 0);
        chk("R1 rx_level", int'(rx_level), 0);
        chk("R1 flags", int'({tx_underflow, tx_ready, rx_overrun, rx_ready, rx_short_read}), 0);
        chk("R1 eng_tx_byte", int'(eng_tx_byte), 0);
        chk("R1 cpu_rdata", int'(cpu_rdata), 0);
        rst_n = 1'b1;

        // R2 R4 R5 R6 R7: low byte first, fill, overfill, drain, underflow
        cycle(1, 0, 16'h2211, 0, 0, 0, 8'h0, 0);
        cycle(1, 0, 16'h4433, 0, 0, 0, 8'h0, 0);
        cycle(1, 0, 16'h6655, 0, 0, 0, 8'h0, 0);   // ignored, full
        cycle(0, 1, 16'h0077, 0, 0, 0, 8'h0, 0);   // ignored, full
        repeat (4) cycle(0, 0, 16'h0, 0, 1, 0, 8'h0, 0);
        cycle(0, 0, 16'h0, 0, 1, 0, 8'h0, 0);      // empty pop
        idle(0);
        cycle(1, 0, 16'hBBAA, 0, 0, 0, 8'h0, 1);   // clears flags, swapped order
        cycle(0, 1, 16'h00CC, 0, 0, 0, 8'h0, 1);   // R3 odd final byte
        cycle(0, 1, 16'h00DD, 0, 1, 0, 8'h0, 1);   // pop with byte write
        repeat (4) cycle(0, 0, 16'h0, 0, 1, 0, 8'h0, 1);
        cycle(0, 1, 16'h00EE, 0, 1, 0, 8'h0, 0);   // empty pop wins over write
        idle(0);

        // R8 R9 R10 R11 R12: fill receive, overflow, read in both orders
        cycle(0, 0, 16'h0, 0, 0, 1, 8'h01, 0);
        cycle(0, 0, 16'h0, 0, 0, 1, 8'h02, 1);
        cycle(0, 0, 16'h0, 0, 0, 1, 8'h03, 0);
        cycle(0, 0, 16'h0, 0, 0, 1, 8'h04, 1);
        cycle(0, 0, 16'h0, 0, 0, 1, 8'h05, 0);     // overflow
        idle(1);
        cycle(0, 0, 16'h0, 1, 0, 0, 8'h0, 0);
        cycle(0, 0, 16'h0, 0, 0, 1, 8'h06, 1);
        cycle(0, 0, 16'h0, 1, 0, 0, 8'h0, 1);
        cycle(0, 0, 16'h0, 1, 0, 0, 8'h0, 0);      // one byte left: short read
        cycle(0, 0, 16'h0, 1, 0, 0, 8'h0, 0);      // empty read: no pulse
        // R13: read and push together, including at full
        repeat (4) cycle(0, 0, 16'h0, 0, 0, 1, 8'h10, 0);
        cycle(0, 0, 16'h0, 1, 0, 1, 8'h20, 0);
        cycle(0, 0, 16'h0, 1, 0, 1, 8'h30, 1);
        cycle(0, 0, 16'h0, 1, 0, 1, 8'h40, 0);
        idle(0);

        // Random traffic
        for (int k = 0; k < 4000; k++) begin
            bit w16, w8;
            w16 = ($urandom % 4) == 0;
            w8  = !w16 && (($urandom % 6) == 0);
            cycle(w16, w8, 16'($urandom), ($urandom % 4) == 0, ($urandom % 3) == 0,
                  ($urandom % 3) == 0, 8'($urandom), ($urandom % 8) == 0);
        end
        @(negedge clk);
        chk_regs();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule